// File: doc/BRIEF.md
# Parallel Variable-Length Instruction Boundary Decoder

This block takes a window of instruction bytes from a fetch buffer and marks where each variable-length instruction begins and how long it is, all within a single clock cycle. Every byte offset of the window has its own length evaluator. Each evaluator computes, speculatively and at the same time as all the others, the length an instruction would have if it began at that offset. A start chain then walks from offset 0 through the real instruction starts. At each start it keeps the speculative length computed there and ignores the lengths at all other offsets.

Each byte carries a continuation flag in bit 7 and a length contribution in bits 2:0. An instruction examines between one and four of its own bytes. Its length is the sum of the contributions of the bytes it examines. An instruction that does not fit inside the valid part of the window is reported as partial, so the fetch logic can keep its bytes for the next window. All results are registered on every cycle in which the input is marked valid.

Top module: `ild_decoder`

## Requirements
- R1: Byte k of the window is `in_bytes[8k+7:8k]`. In any byte that an instruction examines, bit 7 set means the following byte is examined too, and bits 2:0 are that byte's length contribution (0 to 7).
- R2: An instruction examines at most four bytes, starting at its first byte. The fourth byte's continuation bit is ignored, and no fifth byte ever adds to the length.
- R3: An instruction's length is the sum of the contributions of its examined bytes. A sum of 0 is reported as length 1.
- R4: Offset 0 is the first candidate start. When a start at offset j is a complete instruction of length L, offset j+L is the next candidate start.
- R5: `start_mark[j]` is 1 only for complete instructions on the start chain. No bit at or above the effective valid count is ever set.
- R6: A candidate start whose examined bytes or whose length reach past the effective valid count is partial. `partial` is set, that start is not marked, the chain stops there, and `consumed` equals its offset.
- R7: `consumed` is the end offset of the last complete instruction, and it equals the count when the last instruction ends exactly there. A count of 0 gives no marks, `consumed` 0 and `partial` 0. A count above W is treated as W.
- R8: `len_out[6j+5:6j]` holds the length of the instruction at offset j wherever `start_mark[j]` is 1.
- R9: Outputs take the result of the inputs sampled at a rising edge where `in_valid` is 1. When `in_valid` is 0, all outputs hold their values.
- R10: A synchronous active-low reset clears `start_mark`, `len_out`, `consumed` and `partial` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Window bytes and count are valid this cycle |
| in_bytes | input | 8*W | Window bytes, byte k at bits 8k+7:8k |
| in_cnt | input | CW | Number of valid bytes from offset 0 |
| start_mark | output | W | One bit per offset, set at each complete instruction start |
| len_out | output | 6*W | Length per offset, 6 bits each |
| consumed | output | CW | Bytes covered by complete instructions |
| partial | output | 1 | An incomplete instruction was found at offset `consumed` |

## Verification
All of the decoding is combinational and is followed by a single output register. Every result is therefore due at the first rising edge after the window is presented with `in_valid` high. The bench drives inputs on the falling edge and updates its behavioural model at the rising edge that samples them. It then compares every output on the next falling edge, one full cycle after the stimulus. Cycles with `in_valid` low leave the model unchanged, so those comparisons check that the outputs hold. A reset cycle clears the model, so the comparison after it checks that the outputs read zero.

// File: rtl/ild_pkg.sv
// Shared constants for the parallel instruction boundary decoder.
// Assumes byte rule: bit 7 continuation, bits 2:0 contribution.
package ild_pkg;
    localparam int LEN_W     = 6;                 // width of a reported length
    localparam int CONT_BIT  = 7;                 // continuation flag position
    localparam int CONTRIB_W = 3;                 // contribution field width
    localparam int MAX_EXAM  = 4;                 // bytes examined per instruction, max
    localparam int NEX_W     = 3;                 // width of examined-byte count
    localparam int MAX_LEN   = MAX_EXAM * ((1 << CONTRIB_W) - 1);
endpackage

// File: rtl/ild_len_unit.sv
// Speculative length evaluator for one byte offset.
// Assumes it is fed the continuation flags of the first three bytes and the
// contribution fields of the first four bytes at its offset; missing bytes
// past the window arrive as zero. Computes length and examined-byte count.
module ild_len_unit
    import ild_pkg::*;
(
    input  logic [2:0]                      cont_i,     // bit 7 of bytes 0..2
    input  logic [MAX_EXAM*CONTRIB_W-1:0]   contrib_i,  // bits 2:0 of bytes 0..3
    output logic [LEN_W-1:0]                len_o,
    output logic [NEX_W-1:0]                nexam_o
);
    logic [MAX_EXAM-1:0]  take;     // byte k is examined
    logic [LEN_W-1:0]     raw_sum;

    // Examination chain: each byte is taken only if all earlier bytes asked for it.
    always_comb begin
        take[0] = 1'b1;
        for (int k = 1; k < MAX_EXAM; k++) begin
            take[k] = take[k-1] & cont_i[k-1];
        end
    end

    // Sum of contributions of examined bytes and count of examined bytes.
    always_comb begin
        raw_sum = '0;
        nexam_o = '0;
        for (int k = 0; k < MAX_EXAM; k++) begin
            if (take[k]) begin
                raw_sum = raw_sum + LEN_W'(contrib_i[k*CONTRIB_W +: CONTRIB_W]);
                nexam_o = nexam_o + NEX_W'(1);
            end
        end
        len_o = (raw_sum == '0) ? LEN_W'(1) : raw_sum;
    end

    // R3: forward progress is guaranteed by a nonzero, bounded length.
    always_comb begin
        a_r3_len_nonzero: assert (len_o != '0 && len_o <= LEN_W'(MAX_LEN));
    end
endmodule

// File: rtl/ild_start_chain.sv
// Start chain across the window.
// Assumes one speculative length and examined-byte count per offset and an
// effective valid count no larger than W. Follows starts from offset 0, marks
// complete instructions and stops at the first partial one.
module ild_start_chain
    import ild_pkg::*;
#(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
)(
    input  logic [LEN_W-1:0] len_i   [W],
    input  logic [NEX_W-1:0] nexam_i [W],
    input  logic [CW-1:0]    cnt_i,
    output logic [W-1:0]     mark_o,
    output logic [CW-1:0]    cons_o,
    output logic             partial_o
);
    localparam int PW = $clog2(W + MAX_LEN + 1) + 1;

    logic [PW-1:0] pos;
    logic [PW-1:0] cnt_x;

    // Walk offsets in order; only the offset equal to the running position counts.
    always_comb begin
        cnt_x     = PW'(cnt_i);
        pos       = '0;
        mark_o    = '0;
        partial_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (PW'(i) == pos && pos < cnt_x) begin
                if ((PW'(i) + PW'(nexam_i[i]) > cnt_x) ||
                    (PW'(i) + PW'(len_i[i])   > cnt_x)) begin
                    partial_o = 1'b1;          // chain halts: pos stays here
                end else begin
                    mark_o[i] = 1'b1;
                    pos       = pos + PW'(len_i[i]);
                end
            end
        end
        cons_o = CW'(pos);
    end

    // R6: no marked start lies at or beyond the consumed boundary.
    always_comb begin
        a_r6_marks_below_cons: assert ((mark_o >> cons_o) == '0);
    end
endmodule

// File: rtl/ild_decoder.sv
// Top of the parallel instruction boundary decoder.
// Assumes in_bytes holds byte k at bits 8k+7:8k and in_cnt counts valid
// bytes from offset 0 (values above W are clamped). One evaluator per
// offset, one start chain, then a single output register stage.
module ild_decoder
    import ild_pkg::*;
#(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [8*W-1:0]     in_bytes,
    input  logic [CW-1:0]      in_cnt,
    output logic [W-1:0]       start_mark,
    output logic [LEN_W*W-1:0] len_out,
    output logic [CW-1:0]      consumed,
    output logic               partial
);
    logic [CW-1:0]      cnt_eff;
    logic [LEN_W-1:0]   len_w   [W];
    logic [NEX_W-1:0]   nexam_w [W];
    logic [LEN_W*W-1:0] len_flat;
    logic [W-1:0]       mark_w;
    logic [CW-1:0]      cons_w;
    logic               part_w;

    // Clamp the valid count to the window size.
    always_comb begin
        cnt_eff = (in_cnt > CW'(W)) ? CW'(W) : in_cnt;
    end

    // One speculative evaluator per offset.
    for (genvar g = 0; g < W; g++) begin : g_off
        logic [2:0]                    cont;
        logic [MAX_EXAM*CONTRIB_W-1:0] contrib;
        for (genvar k = 0; k < MAX_EXAM; k++) begin : g_byte
            if (g + k < W) begin : g_in
                assign contrib[k*CONTRIB_W +: CONTRIB_W] = in_bytes[8*(g+k) +: CONTRIB_W];
                if (k < MAX_EXAM - 1) begin : g_c
                    assign cont[k] = in_bytes[8*(g+k) + CONT_BIT];
                end
            end else begin : g_out
                assign contrib[k*CONTRIB_W +: CONTRIB_W] = '0;
                if (k < MAX_EXAM - 1) begin : g_c
                    assign cont[k] = 1'b0;
                end
            end
        end
        ild_len_unit u_len (
            .cont_i    (cont),
            .contrib_i (contrib),
            .len_o     (len_w[g]),
            .nexam_o   (nexam_w[g])
        );
        assign len_flat[g*LEN_W +: LEN_W] = len_w[g];
    end

    ild_start_chain #(.W(W), .CW(CW)) u_chain (
        .len_i     (len_w),
        .nexam_i   (nexam_w),
        .cnt_i     (cnt_eff),
        .mark_o    (mark_w),
        .cons_o    (cons_w),
        .partial_o (part_w)
    );

    // Output register: load on valid input, clear on reset, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_mark <= '0;
            len_out    <= '0;
            consumed   <= '0;
            partial    <= 1'b0;
        end else if (in_valid) begin
            start_mark <= mark_w;
            len_out    <= len_flat;
            consumed   <= cons_w;
            partial    <= part_w;
        end
    end

    // R10: a reset cycle leaves all outputs cleared.
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (start_mark == '0 && len_out == '0 && consumed == '0 && !partial));

    // R9: outputs hold while no valid window is presented.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(start_mark) && $stable(len_out) && $stable(consumed) && $stable(partial)));

    // R7: consumed never exceeds the sampled effective count.
    a_r7_cons_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (consumed <= $past(cnt_eff)));

    // R5: no start mark at or beyond the sampled effective count.
    a_r5_no_mark_past: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((start_mark >> $past(cnt_eff)) == '0));

    // R6: a partial result leaves the consumed boundary strictly inside the count.
    a_r6_partial_inside: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!partial || consumed < $past(cnt_eff)));
endmodule

// File: tb/tb_ild_decoder.sv
`timescale 1ns/1ps
module tb_ild_decoder;
    localparam int W  = 64;
    localparam int CW = $clog2(W + 1);
    localparam int LW = 6;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [8*W-1:0]    in_bytes;
    logic [CW-1:0]     in_cnt;
    logic [W-1:0]      start_mark;
    logic [LW*W-1:0]   len_out;
    logic [CW-1:0]     consumed;
    logic              partial;

    ild_decoder #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
        .in_cnt(in_cnt), .start_mark(start_mark), .len_out(len_out),
        .consumed(consumed), .partial(partial)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0]  bb [W];
    logic [W-1:0] e_mark;
    int          e_len [W];
    int          e_cons;
    bit          e_part;

    // Behavioural reference: walk the bytes one instruction at a time.
    task automatic model(input int cnt);
        int pos, n, len, k;
        bit go;
        if (cnt > W) cnt = W;
        e_mark = '0; e_part = 0; pos = 0;
        for (int i = 0; i < W; i++) e_len[i] = 0;
        while (pos < cnt && !e_part) begin
            len = bb[pos][2:0]; n = 1; k = pos; go = bb[pos][7];
            while (go && n < 4) begin
                k++; n++;
                if (k < W) begin len += bb[k][2:0]; go = bb[k][7]; end
                else go = 0;
            end
            if (len == 0) len = 1;
            if (pos + n > cnt || pos + len > cnt) e_part = 1;
            else begin e_mark[pos] = 1'b1; e_len[pos] = len; pos += len; end
        end
        e_cons = pos;
    endtask

    task automatic chk(input string tag, input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        n_cmp++;
        if (start_mark !== e_mark) begin
            n_bad++;
            $display("FAIL %s start_mark: actual %h expected %h", tag, start_mark, e_mark);
        end
        chk(tag, int'(consumed), e_cons, "consumed");
        chk(tag, int'(partial), int'(e_part), "partial");
        for (int j = 0; j < W; j++)
            if (e_mark[j]) chk(tag, int'(len_out[j*LW +: LW]), e_len[j], $sformatf("len@%0d", j));
    endtask

    // Drive at falling edge, model at rising edge, compare at next falling edge.
    task automatic apply(input bit v, input int cnt, input string tag);
        for (int j = 0; j < W; j++) in_bytes[8*j +: 8] = bb[j];
        in_valid = v;
        in_cnt   = CW'(cnt);
        @(posedge clk);
        if (!rst_n) begin
            e_mark = '0; e_cons = 0; e_part = 0;
            for (int i = 0; i < W; i++) e_len[i] = 0;
        end else if (v) model(cnt);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic fill(input logic [7:0] b);
        for (int j = 0; j < W; j++) bb[j] = b;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_cnt = '0; in_bytes = '0;
        fill(8'h00);
        @(negedge clk);
        apply(1, 64, "R10");                 // reset state
        rst_n = 1'b1;

        fill(8'h01); apply(1, 64, "R1");     // one-byte instructions everywhere
        fill(8'h02); apply(1, 64, "R4");     // starts on even offsets
        fill(8'h00); apply(1, 64, "R3");     // zero sums forced to 1
        // four-byte cap: fourth byte asks to continue but is final
        fill(8'h01);
        bb[0] = 8'h83; bb[1] = 8'h82; bb[2] = 8'h81; bb[3] = 8'h87; bb[4] = 8'h85;
        apply(1, 64, "R2");
        // continuation with zero contributions gives length 1
        fill(8'h01); bb[0] = 8'h80; bb[1] = 8'h00;
        apply(1, 64, "R3");
        // partial by length: start at 8 has length 5 with count 10
        fill(8'h02); bb[8] = 8'h05;
        apply(1, 10, "R6");
        // partial by examined bytes: last valid byte asks for another
        fill(8'h01); bb[9] = 8'h81;
        apply(1, 10, "R6");
        // exact fit ends at the count
        fill(8'h03); apply(1, 12, "R7");
        fill(8'h01); apply(1, 0, "R7");      // empty window
        fill(8'h04); apply(1, 100, "R7");    // count above W clamps
        // hold while not valid, with different bytes and count
        fill(8'h07); apply(0, 30, "R9");
        apply(0, 5, "R9");
        // length field placement under mixed lengths
        for (int j = 0; j < W; j++) bb[j] = 8'(j % 6);
        apply(1, 64, "R8");
        // random windows
        for (int t = 0; t < 300; t++) begin
            for (int j = 0; j < W; j++) bb[j] = 8'($urandom);
            apply(($urandom % 5) != 0, int'($urandom % 70), "R5");
        end
        // mid-run reset
        rst_n = 1'b0; fill(8'h01); apply(1, 64, "R10");
        rst_n = 1'b1; apply(1, 64, "R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule